// File: doc/BRIEF.md
# Multi-Channel Countdown Timer Bank

This block is a bank of independent down-counting timers reached through a zero-wait-state APB slave. Software writes a start count, picks a reload behaviour, and sets an enable bit. The channel then counts one step per clock and flags an expiry each time its count passes through zero. Each channel drives its own interrupt line, which is meant to be seen as an edge by the interrupt controller.

A channel has two reload behaviours. In periodic mode it reloads its start count, which gives a fixed tick. In free-running mode it reloads the all-ones value, which leaves software a full 2^32-step window to re-arm it. This second mode is how a single-shot event is emulated. A read of the channel's acknowledge register clears its pending flag. The bank also exposes a read-only identification word at a fixed address.

Top module: `apb_countdown_bank`

## Requirements
- R1: After reset, every channel register reads zero, every interrupt line is low, PREADY is high and PSLVERR is low.
- R2: The start-count register (channel offset 0x00) is fully readable and writable. Writing it does not change a count that is already running.
- R3: A 0-to-1 transition of the enable bit (control offset 0x08, bit 0) loads the counter from the start count in the same edge. While enabled, the counter drops by one per clock. While disabled, it holds. Rewriting control while already enabled does not reload.
- R4: With the mode bit (control bit 1) set to 1 and a count of zero, the next edge reloads the start count and sets the pending flag. A start count of L therefore expires L+1 cycles after the enabling write, and every L+1 cycles after that.
- R5: With the mode bit set to 0 and a count of zero, the next edge reloads 0xFFFFFFFF and sets the pending flag.
- R6: Control bit 2 set to 1 masks the channel. The pending flag (offset 0x10, bit 0) still sets on expiry, but the interrupt line stays low. The line equals pending AND NOT mask and is updated on the same edge as either of them.
- R7: An APB read of the acknowledge register (offset 0x0C) returns zero and clears the pending flag and the line on its access edge. An expiry on that same edge wins, so the flag stays set.
- R8: Channel c occupies addresses c*0x14 to c*0x14+0x13. The identification word is at 0xAC. Reads of any other address, and of addresses not aligned to 4 bytes, return zero. Writes to the count-value (offset 0x04), acknowledge, pending and identification registers, and to unmapped addresses, have no effect. Control reads return only bits 2:0.
- R9: Read data is taken from register state at the setup-phase edge and held through the access phase. Every transfer completes without wait states.
- R10: Channels are independent. Programming or acknowledging one channel leaves the count, pending flag and interrupt line of every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and count clock |
| prst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data |
| pready | output | 1 | Transfer complete, always high |
| pslverr | output | 1 | Error response, always low |
| tmr_irq | output | NUM_CH | One interrupt line per channel |

## Verification
The bench counts rising edges and records the edge on which each enabling write is accepted. A channel loaded with L must therefore still show its line low L edges later and high one edge after that, and the bench samples at exactly those two points on the falling edge. Read data reflects the state at the setup edge, so a value read that starts right after an enabling write must return L exactly. After a free-running expiry, the read must return all ones. An acknowledge is placed so that its access edge falls on an expiry edge, which checks that the set wins. Mask and acknowledge effects are checked on the falling edge right after the access edge.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

  // Register offsets inside one channel window
  localparam int OFF_LOAD  = 'h00;
  localparam int OFF_VALUE = 'h04;
  localparam int OFF_CTRL  = 'h08;
  localparam int OFF_ACK   = 'h0C;
  localparam int OFF_PEND  = 'h10;

  // Control word: bit0 enable, bit1 periodic, bit2 mask
  typedef struct packed {
    logic mask;
    logic periodic;
    logic en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/cdt_addr_decode.sv
module cdt_addr_decode #(
  parameter int NUM_CH   = 8,
  parameter int ADDR_W   = 8,
  parameter int STRIDE   = 20,
  parameter int VER_ADDR = 'hAC
) (
  input  logic [ADDR_W-1:0] paddr,
  output logic [NUM_CH-1:0] ch_hit,
  output logic [ADDR_W-1:0] ch_off,
  output logic              ver_hit
);

  logic aligned;
  logic [NUM_CH-1:0][ADDR_W-1:0] off_arr;

  assign aligned = (paddr[1:0] == 2'b00);
  assign ver_hit = aligned && (int'(paddr) == VER_ADDR);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_win
    localparam int BASE = c * STRIDE;
    assign ch_hit[c]  = aligned && (int'(paddr) >= BASE) && (int'(paddr) < BASE + STRIDE);
    assign off_arr[c] = ch_hit[c] ? ADDR_W'(int'(paddr) - BASE) : '0;
  end

  always_comb begin
    ch_off = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      ch_off = ch_off | off_arr[c];
    end
  end

endmodule

// File: rtl/cdt_channel.sv
module cdt_channel
  import cdt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_load,
  input  logic              wr_ctrl,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ack_rd,
  output logic [DATA_W-1:0] load_q,
  output logic [DATA_W-1:0] cnt_q,
  output ctrl_t             ctrl_q,
  output logic              pend_q,
  output logic              irq_q
);

  ctrl_t             ctrl_d;
  logic [DATA_W-1:0] cnt_d;
  logic              pend_d;
  logic              expire;
  logic              start;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) ctrl_d = ctrl_t'(wdata[CTRL_W-1:0]);

    start  = ctrl_d.en && !ctrl_q.en;
    expire = ctrl_q.en && (cnt_q == '0);

    cnt_d = cnt_q;
    if (start)             cnt_d = load_q;
    else if (expire)       cnt_d = ctrl_q.periodic ? load_q : '1;
    else if (ctrl_q.en)    cnt_d = cnt_q - DATA_W'(1);

    // acknowledge clears, a coincident expiry sets again
    pend_d = pend_q;
    if (ack_rd) pend_d = 1'b0;
    if (expire) pend_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q <= '0;
      cnt_q  <= '0;
      ctrl_q <= '0;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_load) load_q <= wdata;
      cnt_q  <= cnt_d;
      ctrl_q <= ctrl_d;
      pend_q <= pend_d;
      irq_q  <= pend_d && !ctrl_d.mask;
    end
  end

endmodule

// File: rtl/apb_countdown_bank.sv
module apb_countdown_bank
  import cdt_pkg::*;
#(
  parameter int          NUM_CH   = 8,
  parameter int          ADDR_W   = 8,
  parameter int          DATA_W   = 32,
  parameter int          STRIDE   = 20,
  parameter int          VER_ADDR = 'hAC,
  parameter logic [31:0] VERSION  = 32'h3131_302A
) (
  input  logic              pclk,
  input  logic              prst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  output logic [NUM_CH-1:0] tmr_irq
);

  localparam logic [ADDR_W-1:0] A_LOAD  = ADDR_W'(OFF_LOAD);
  localparam logic [ADDR_W-1:0] A_VALUE = ADDR_W'(OFF_VALUE);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_ACK   = ADDR_W'(OFF_ACK);
  localparam logic [ADDR_W-1:0] A_PEND  = ADDR_W'(OFF_PEND);

  logic [NUM_CH-1:0]             ch_hit;
  logic [ADDR_W-1:0]             ch_off;
  logic                          ver_hit;
  logic                          setup_ph;
  logic                          wr_acc;
  logic                          rd_acc;
  logic [DATA_W-1:0]             rd_mux;
  logic [DATA_W-1:0]             prdata_q;

  logic [NUM_CH-1:0][DATA_W-1:0] cnt_w;
  logic [NUM_CH-1:0][DATA_W-1:0] load_w;
  logic [NUM_CH-1:0]             en_w;
  logic [NUM_CH-1:0]             mode_w;
  logic [NUM_CH-1:0]             mask_w;
  logic [NUM_CH-1:0]             pend_w;

  assign setup_ph = psel && !penable;
  assign wr_acc   = psel && penable && pwrite;
  assign rd_acc   = psel && penable && !pwrite;
  assign pready   = 1'b1;
  assign pslverr  = 1'b0;

  cdt_addr_decode #(
    .NUM_CH  (NUM_CH),
    .ADDR_W  (ADDR_W),
    .STRIDE  (STRIDE),
    .VER_ADDR(VER_ADDR)
  ) u_dec (
    .paddr  (paddr),
    .ch_hit (ch_hit),
    .ch_off (ch_off),
    .ver_hit(ver_hit)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ctrl_t ctrl_c;

    cdt_channel #(.DATA_W(DATA_W)) u_ch (
      .clk    (pclk),
      .rst    (prst),
      .wr_load(wr_acc && ch_hit[c] && (ch_off == A_LOAD)),
      .wr_ctrl(wr_acc && ch_hit[c] && (ch_off == A_CTRL)),
      .wdata  (pwdata),
      .ack_rd (rd_acc && ch_hit[c] && (ch_off == A_ACK)),
      .load_q (load_w[c]),
      .cnt_q  (cnt_w[c]),
      .ctrl_q (ctrl_c),
      .pend_q (pend_w[c]),
      .irq_q  (tmr_irq[c])
    );

    assign en_w[c]   = ctrl_c.en;
    assign mode_w[c] = ctrl_c.periodic;
    assign mask_w[c] = ctrl_c.mask;
  end

  always_comb begin
    rd_mux = '0;
    if (ver_hit) rd_mux = DATA_W'(VERSION);
    for (int c = 0; c < NUM_CH; c++) begin
      if (ch_hit[c]) begin
        case (ch_off)
          A_LOAD:  rd_mux = load_w[c];
          A_VALUE: rd_mux = cnt_w[c];
          A_CTRL:  rd_mux = DATA_W'({mask_w[c], mode_w[c], en_w[c]});
          A_PEND:  rd_mux = DATA_W'(pend_w[c]);
          default: rd_mux = '0;
        endcase
      end
    end
  end

  // read data captured at the setup edge, held for the access phase
  always_ff @(posedge pclk) begin
    if (prst)          prdata_q <= '0;
    else if (setup_ph) prdata_q <= rd_mux;
  end

  assign prdata = prdata_q;

endmodule

// File: rtl/cdt_checker.sv
module cdt_checker #(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 32
) (
  input logic                          clk,
  input logic                          rst,
  input logic [NUM_CH-1:0][DATA_W-1:0] cnt,
  input logic [NUM_CH-1:0][DATA_W-1:0] load,
  input logic [NUM_CH-1:0]             en,
  input logic [NUM_CH-1:0]             mode,
  input logic [NUM_CH-1:0]             mask,
  input logic [NUM_CH-1:0]             pend,
  input logic [NUM_CH-1:0]             irq
);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_prop
    // R6
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
      irq[i] == (pend[i] && !mask[i]));

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
      (en[i] && cnt[i] != '0) |=> cnt[i] == $past(cnt[i]) - DATA_W'(1));

    // R3
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !en[i] |=> (en[i] || $stable(cnt[i])));

    // R4
    periodic_reload_chk: assert property (@(posedge clk) disable iff (rst)
      (en[i] && mode[i] && cnt[i] == '0) |=> cnt[i] == $past(load[i]));

    // R5
    free_reload_chk: assert property (@(posedge clk) disable iff (rst)
      (en[i] && !mode[i] && cnt[i] == '0) |=> cnt[i] == '1);

    // R4
    expire_flag_chk: assert property (@(posedge clk) disable iff (rst)
      (en[i] && cnt[i] == '0) |=> pend[i]);
  end

endmodule

bind apb_countdown_bank cdt_checker #(
  .NUM_CH(NUM_CH),
  .DATA_W(DATA_W)
) u_chk (
  .clk (pclk),
  .rst (prst),
  .cnt (cnt_w),
  .load(load_w),
  .en  (en_w),
  .mode(mode_w),
  .mask(mask_w),
  .pend(pend_w),
  .irq (tmr_irq)
);

// File: tb/tb_apb_countdown_bank.sv
`timescale 1ns/1ps
module tb_apb_countdown_bank;

  localparam int          NCH     = 8;
  localparam int          STEP    = 'h14;
  localparam logic [31:0] VER_EXP = 32'h3131_302A;

  logic        pclk = 1'b0;
  logic        prst = 1'b1;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic [NCH-1:0] tmr_irq;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #4 pclk = ~pclk;
  always @(posedge pclk) cyc <= cyc + 1;

  apb_countdown_bank dut (
    .pclk(pclk), .prst(prst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .tmr_irq(tmr_irq)
  );

  function automatic logic [7:0] ra(input int ch, input int off);
    return 8'(ch * STEP + off);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // all bus tasks start and end on a falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge pclk); penable = 1'b1;
    @(negedge pclk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge pclk); penable = 1'b1;
    @(negedge pclk); d = prdata; psel = 1'b0; penable = 1'b0;
  endtask

  task automatic wait_cyc(input int c);
    while (cyc < c) @(negedge pclk);
  endtask

  initial begin
    repeat (100000) @(posedge pclk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      summary();
    end
  end

  initial begin
    logic [31:0] v, v2;
    int w, ld, ch;
    void'($urandom(32'd17));
    repeat (4) @(negedge pclk);
    prst = 1'b0;
    @(negedge pclk);

    // R1 reset state
    chk(tmr_irq == '0, "R1 irq", 32'(tmr_irq), 0);
    chk(pready && !pslverr, "R1 pready/pslverr", {30'b0, pready, pslverr}, 32'h2);
    for (int c = 0; c < NCH; c++) begin
      for (int o = 0; o < STEP; o += 4) begin
        rd(ra(c, o), v);
        chk(v == 0, "R1 reg", v, 0);
      end
    end
    rd(8'hAC, v); chk(v == VER_EXP, "R8 version", v, VER_EXP);

    // R2 load register readback
    wr(ra(0, 'h00), 32'hDEADBEEF);
    rd(ra(0, 'h00), v); chk(v == 32'hDEADBEEF, "R2 load rw", v, 32'hDEADBEEF);

    // R3/R4 periodic on ch1, L=20
    ld = 20;
    wr(ra(1, 'h00), 32'(ld));
    wr(ra(1, 'h08), 32'h3); w = cyc;
    rd(ra(1, 'h04), v); chk(v == 32'(ld), "R3 start load", v, 32'(ld));
    rd(ra(1, 'h04), v2); chk(v2 == 32'(ld - 2), "R3 decrement", v2, 32'(ld - 2));
    wr(ra(1, 'h00), 32'd500);  // R2: must not disturb running count
    wait_cyc(w + ld);
    chk(tmr_irq[1] == 1'b0, "R4 before expiry", 32'(tmr_irq[1]), 0);
    wait_cyc(w + ld + 1);
    chk(tmr_irq[1] == 1'b1, "R4 expiry edge", 32'(tmr_irq[1]), 1);
    rd(ra(1, 'h10), v); chk(v == 1, "R4 pending", v, 1);
    rd(ra(1, 'h0C), v); chk(v == 0, "R7 ack reads zero", v, 0);
    chk(tmr_irq[1] == 1'b0, "R7 ack clears line", 32'(tmr_irq[1]), 0);
    rd(ra(1, 'h10), v); chk(v == 0, "R7 ack clears pending", v, 0);
    // second period uses the start count written while running (500)
    wait_cyc(w + ld + 1 + 500);
    chk(tmr_irq[1] == 1'b0, "R2 new load used on reload", 32'(tmr_irq[1]), 0);
    wait_cyc(w + ld + 1 + 501);
    chk(tmr_irq[1] == 1'b1, "R4 second expiry", 32'(tmr_irq[1]), 1);
    wr(ra(1, 'h08), 32'h0); rd(ra(1, 'h0C), v);

    // R7 acknowledge on the same edge as an expiry
    wr(ra(5, 'h00), 32'd6);
    wr(ra(5, 'h08), 32'h3); w = cyc;
    wait_cyc(w + 12);
    rd(ra(5, 'h0C), v);
    chk(cyc == w + 14, "R7 timing", 32'(cyc), 32'(w + 14));
    chk(tmr_irq[5] == 1'b1, "R7 expiry wins", 32'(tmr_irq[5]), 1);
    wr(ra(5, 'h08), 32'h0); rd(ra(5, 'h0C), v);

    // R6 mask
    wr(ra(2, 'h00), 32'd10);
    wr(ra(2, 'h08), 32'h7); w = cyc;
    wait_cyc(w + 11);
    chk(tmr_irq[2] == 1'b0, "R6 masked line", 32'(tmr_irq[2]), 0);
    rd(ra(2, 'h10), v); chk(v == 1, "R6 pending while masked", v, 1);
    wr(ra(2, 'h08), 32'h3);
    chk(tmr_irq[2] == 1'b1, "R6 unmask raises", 32'(tmr_irq[2]), 1);
    rd(ra(2, 'h08), v); chk(v == 3, "R3 rewrite keeps enable", v, 3);
    wr(ra(2, 'h08), 32'h0); rd(ra(2, 'h0C), v);

    // R5 free running
    wr(ra(3, 'h00), 32'd5);
    wr(ra(3, 'h08), 32'h1); w = cyc;
    wait_cyc(w + 6);
    chk(tmr_irq[3] == 1'b1, "R5 expiry", 32'(tmr_irq[3]), 1);
    rd(ra(3, 'h04), v); chk(v == 32'hFFFFFFFF, "R5 reload all ones", v, 32'hFFFFFFFF);

    // R3 disable holds, re-enable reloads
    wr(ra(3, 'h08), 32'h0);
    rd(ra(3, 'h04), v); repeat (5) @(negedge pclk); rd(ra(3, 'h04), v2);
    chk(v == v2, "R3 hold when disabled", v2, v);
    wr(ra(3, 'h00), 32'd77);
    wr(ra(3, 'h08), 32'h1);
    rd(ra(3, 'h04), v); chk(v == 77, "R3 re-enable loads", v, 77);
    wr(ra(3, 'h08), 32'h0); rd(ra(3, 'h0C), v);
    chk(tmr_irq == '0, "R10 all lines clear", 32'(tmr_irq), 0);

    // R8 read-only writes ignored, unmapped reads zero
    wr(ra(4, 'h04), 32'h1234); rd(ra(4, 'h04), v); chk(v == 0, "R8 value ro", v, 0);
    wr(ra(4, 'h10), 32'h1);    rd(ra(4, 'h10), v); chk(v == 0, "R8 pending ro", v, 0);
    wr(8'hAC, 32'h0);          rd(8'hAC, v); chk(v == VER_EXP, "R8 version ro", v, VER_EXP);
    wr(ra(4, 'h08), 32'hFFFFFFF8); rd(ra(4, 'h08), v); chk(v == 0, "R8 ctrl width", v, 0);
    rd(8'hA0, v); chk(v == 0, "R8 unmapped A0", v, 0);
    rd(8'hFC, v); chk(v == 0, "R8 unmapped FC", v, 0);
    wr(8'h01, 32'hFFFF); rd(8'h01, v); chk(v == 0, "R8 misaligned", v, 0);
    rd(ra(0, 'h00), v); chk(v == 32'hDEADBEEF, "R8 misaligned write ignored", v, 32'hDEADBEEF);

    // R9 zero wait states
    chk(pready == 1'b1, "R9 pready", 32'(pready), 1);

    // R10 random channels, random periods
    for (int it = 0; it < 8; it++) begin
      ch = 4 + int'($urandom_range(3));
      ld = 8 + int'($urandom_range(32));
      wr(ra(ch, 'h00), 32'(ld));
      wr(ra(ch, 'h08), 32'h3); w = cyc;
      rd(ra(ch, 'h04), v); chk(v == 32'(ld), "R10 start value", v, 32'(ld));
      wait_cyc(w + ld);
      chk(tmr_irq == '0, "R10 no early line", 32'(tmr_irq), 0);
      wait_cyc(w + ld + 1);
      chk(tmr_irq == NCH'(1 << ch), "R10 only own line", 32'(tmr_irq), 32'(1 << ch));
      wr(ra(ch, 'h08), 32'h0); rd(ra(ch, 'h0C), v);
      chk(tmr_irq == '0, "R10 cleared", 32'(tmr_irq), 0);
    end

    // R2 random readback on all channels
    for (int it = 0; it < 16; it++) begin
      ch = int'($urandom_range(NCH - 1));
      v2 = $urandom;
      wr(ra(ch, 'h00), v2);
      rd(ra(ch, 'h00), v); chk(v == v2, "R2 random load", v, v2);
    end

    done = 1'b1;
    summary();
  end

endmodule